// File: doc/BRIEF.md
# Ultrasonic Ranging Target Emulator

This block stands in for a trigger/echo ultrasonic distance sensor so that a ranging controller can be exercised against a known, programmable target. The controller drives a trigger line. The block measures how long that line stays high after synchronising it. When the pulse is long enough and the block is free to start a new measurement, the block takes the pulse on its falling edge.

After it takes a trigger, the block plays out a short 40 kHz transmit burst. It then raises its echo line for the round-trip flight time of sound to a target at the programmed distance, using 340 m/s. The distance input is in millimetres and is captured when the trigger is taken. Distances below the near limit are pulled up to that limit. Distances beyond the far limit count as "nothing in range", and the echo then stays high for a fixed timeout.

The block computes all timing from a clock-frequency parameter. A bench or board can shrink the long windows through parameters.

Top module: `sonar_echo_emu`

## Requirements
- R1: A trigger is taken only if the synchronised trigger has been high for at least ceil(CLK_HZ*TRIG_MIN_US/1e6) clocks when it falls. This is 14 clocks at 1.36 MHz. A shorter pulse starts nothing.
- R2: A taken trigger produces a burst of exactly BURST_PULSES (8) square-wave periods. Each half period lasts CLK_HZ/(2*BURST_HZ) clocks. The waveform starts high. burst_active_o is high for the whole burst, and burst_wave_o is low whenever burst_active_o is low.
- R3: echo_o rises on the same clock edge where burst_active_o falls.
- R4: For an in-range distance d, the echo high time is (d*S)>>8 clocks, where S = round(CLK_HZ*512/(SOUND_MPS*1000)). That is 8 clocks per millimetre at 1.36 MHz, which gives better than 3 mm resolution.
- R5: A distance below MIN_MM (20 mm) gives the echo width of MIN_MM.
- R6: A distance above MAX_MM (4000 mm) gives an echo width of CLK_HZ*TIMEOUT_US/1e6 clocks.
- R7: A trigger taken while a burst or echo is in progress is ignored.
- R8: A trigger is taken only if at least CLK_HZ*CYCLE_US/1e6 clock edges have passed since the previous accepted trigger. A trigger that completes earlier is ignored.
- R9: burst_active_o rises on the third rising clock edge after the trigger input falls. Two of these edges are the synchroniser flops and one is the state register.
- R10: The distance is captured when the trigger is taken. Later changes to dist_mm_i do not alter the echo in progress.
- R11: An active reset forces echo_o, burst_active_o and burst_wave_o low at once. After reset a valid trigger is accepted without waiting for a measurement cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Asynchronous trigger from the ranging controller |
| dist_mm_i | input | DIST_W | Emulated target distance in millimetres |
| echo_o | output | 1 | Echo pulse whose width encodes the distance |
| burst_active_o | output | 1 | High while the transmit burst plays |
| burst_wave_o | output | 1 | 40 kHz transmit burst waveform |

## Verification
The bench drives inputs on the falling clock edge and samples outputs on the falling edge. A trigger that falls at negedge N must show burst_active_o low at the sample after two rising edges and high at the sample after the third. From that first high sample, the bench counts burst samples, waveform highs and waveform rises. At the first sample where burst_active_o is low, echo_o must already be high. The echo width is the number of consecutive high samples, compared against (clamped distance × 8) or the 680-clock timeout.

For the cycle rule, the bench counts falling edges from the first burst sample. A trigger released at count c is taken on edge A+c+3, where A is the edge that started the previous burst. So releasing at count 1356 must be ignored and releasing at count 1357 must be accepted.

// File: rtl/sonar_pkg.sv
package sonar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_ECHO  = 2'd2
  } meas_st_e;
endpackage

// File: rtl/sonar_rst_sync.sv
module sonar_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/sonar_trig_qual.sv
module sonar_trig_qual #(
  parameter int MIN_CYC = 500,
  parameter int WID_W   = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic fire_o
);
  logic             meta_q, sync_q, del_q;
  logic [WID_W-1:0] wid_q, wid_d;

  // saturating count of synchronised high cycles
  always_comb begin
    if (!sync_q)
      wid_d = '0;
    else if (wid_q == WID_W'(MIN_CYC))
      wid_d = wid_q;
    else
      wid_d = wid_q + WID_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      del_q  <= 1'b0;
      wid_q  <= '0;
    end else begin
      meta_q <= trig_i;
      sync_q <= meta_q;
      del_q  <= sync_q;
      wid_q  <= wid_d;
    end
  end

  assign fire_o = del_q & ~sync_q & (wid_q == WID_W'(MIN_CYC));

  AST_WIDTH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    wid_q <= WID_W'(MIN_CYC)); // R1
  AST_FIRE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(sync_q) && !sync_q); // R1
endmodule

// File: rtl/sonar_range_calc.sv
module sonar_range_calc #(
  parameter int DIST_W      = 16,
  parameter int ECHO_W      = 21,
  parameter int MIN_MM      = 20,
  parameter int MAX_MM      = 4000,
  parameter int SCALE       = 75294,
  parameter int SCALE_W     = 17,
  parameter int FRAC        = 8,
  parameter int TIMEOUT_CYC = 1900000
) (
  input  logic [DIST_W-1:0] dist_i,
  output logic [ECHO_W-1:0] len_o
);
  localparam int PROD_W = DIST_W + SCALE_W;

  logic              no_tgt;
  logic [DIST_W-1:0] clamped;
  logic [PROD_W-1:0] prod;

  always_comb begin
    no_tgt  = dist_i > DIST_W'(MAX_MM);
    clamped = (dist_i < DIST_W'(MIN_MM)) ? DIST_W'(MIN_MM) : dist_i;
    prod    = {{SCALE_W{1'b0}}, clamped} * {{DIST_W{1'b0}}, SCALE_W'(SCALE)};
    len_o   = no_tgt ? ECHO_W'(TIMEOUT_CYC) : ECHO_W'(prod >> FRAC);
  end
endmodule

// File: rtl/sonar_meas_fsm.sv
module sonar_meas_fsm
  import sonar_pkg::*;
#(
  parameter int HALF_CYC  = 625,
  parameter int PULSES    = 8,
  parameter int CYCLE_CYC = 3000000,
  parameter int DIST_W    = 16,
  parameter int ECHO_W    = 21,
  parameter int CYC_W     = $clog2(CYCLE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic [ECHO_W-1:0] echo_len_i,
  output logic [DIST_W-1:0] dist_q_o,
  output logic              burst_active_o,
  output logic              burst_wave_o,
  output logic              echo_o
);
  localparam int HALF_W = $clog2(HALF_CYC + 1);
  localparam int EDGE_W = (2 * PULSES > 1) ? $clog2(2 * PULSES) : 1;
  localparam int LAST_EDGE = 2 * PULSES - 1;

  meas_st_e          st_q, st_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [ECHO_W-1:0] echo_q, echo_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [DIST_W-1:0] dist_q, dist_d;
  logic              ready, accept, cyc_en;

  assign ready  = (st_q == ST_IDLE) && (cyc_q == '0);
  assign accept = fire_i & ready;
  assign cyc_en = accept || (cyc_q != '0);

  always_comb begin
    st_d   = st_q;
    half_d = half_q;
    edge_d = edge_q;
    echo_d = echo_q;
    dist_d = dist_q;
    cyc_d  = (cyc_q != '0) ? cyc_q - CYC_W'(1) : cyc_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_BURST;
          half_d = '0;
          edge_d = '0;
          dist_d = dist_i;
          cyc_d  = CYC_W'(CYCLE_CYC - 1);
        end
      end
      ST_BURST: begin
        if (half_q == HALF_W'(HALF_CYC - 1)) begin
          half_d = '0;
          if (edge_q == EDGE_W'(LAST_EDGE)) begin
            st_d   = ST_ECHO;
            echo_d = echo_len_i - ECHO_W'(1);
          end else begin
            edge_d = edge_q + EDGE_W'(1);
          end
        end else begin
          half_d = half_q + HALF_W'(1);
        end
      end
      ST_ECHO: begin
        if (echo_q == '0)
          st_d = ST_IDLE;
        else
          echo_d = echo_q - ECHO_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= '0;
      edge_q <= '0;
      echo_q <= '0;
      dist_q <= '0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      edge_q <= edge_d;
      echo_q <= echo_d;
      dist_q <= dist_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cyc_q <= '0;
    else if (cyc_en)
      cyc_q <= cyc_d;
  end

  assign dist_q_o       = dist_q;
  assign burst_active_o = (st_q == ST_BURST);
  assign burst_wave_o   = (st_q == ST_BURST) & ~edge_q[0];
  assign echo_o         = (st_q == ST_ECHO);

  AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active_o |-> !burst_wave_o); // R2
  AST_ECHO_FOLLOWS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_active_o) |-> echo_o); // R3
  AST_ECHO_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(echo_o) |-> $past(burst_active_o)); // R3
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active_o |-> echo_len_i != '0); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && st_q == ST_ECHO) |=> st_q != ST_BURST); // R7
  AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_active_o) |-> $past(cyc_q) == '0); // R8
  AST_DIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) && ($past(st_q) != ST_IDLE) |-> $stable(dist_q)); // R10
endmodule

// File: rtl/sonar_echo_emu.sv
module sonar_echo_emu #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int TRIG_MIN_US  = 10,
  parameter int BURST_HZ     = 40_000,
  parameter int BURST_PULSES = 8,
  parameter int CYCLE_US     = 60_000,
  parameter int TIMEOUT_US   = 38_000,
  parameter int MIN_MM       = 20,
  parameter int MAX_MM       = 4000,
  parameter int SOUND_MPS    = 340,
  parameter int FRAC         = 8,
  parameter int DIST_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [DIST_W-1:0] dist_mm_i,
  output logic              echo_o,
  output logic              burst_active_o,
  output logic              burst_wave_o
);
  localparam longint TRIG_L    = (longint'(CLK_HZ) * longint'(TRIG_MIN_US) + 64'd999999) / 64'd1000000;
  localparam longint CYCLE_L   = (longint'(CLK_HZ) * longint'(CYCLE_US)) / 64'd1000000;
  localparam longint TIMEOUT_L = (longint'(CLK_HZ) * longint'(TIMEOUT_US)) / 64'd1000000;
  localparam longint SCALE_L   = (longint'(CLK_HZ) * 64'd2 * (64'd1 << FRAC) + longint'(SOUND_MPS) * 64'd500)
                                 / (longint'(SOUND_MPS) * 64'd1000);
  localparam longint MAXLEN_L  = (longint'(MAX_MM) * SCALE_L) >> FRAC;
  localparam longint LONGEST_L = (MAXLEN_L > TIMEOUT_L) ? MAXLEN_L : TIMEOUT_L;

  localparam int TRIG_MIN_CYC = int'(TRIG_L);
  localparam int CYCLE_CYC    = int'(CYCLE_L);
  localparam int TIMEOUT_CYC  = int'(TIMEOUT_L);
  localparam int SCALE        = int'(SCALE_L);
  localparam int SCALE_W      = $clog2(SCALE + 1);
  localparam int HALF_CYC     = CLK_HZ / (2 * BURST_HZ);
  localparam int ECHO_W       = $clog2(LONGEST_L + 1);
  localparam int CYC_W        = $clog2(CYCLE_CYC + 1);
  localparam int WID_W        = $clog2(TRIG_MIN_CYC + 1);

  logic              rst_sync_n;
  logic              fire;
  logic [DIST_W-1:0] dist_held;
  logic [ECHO_W-1:0] echo_len;

  sonar_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  sonar_trig_qual #(
    .MIN_CYC (TRIG_MIN_CYC),
    .WID_W   (WID_W)
  ) u_trig_qual (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .trig_i (trig_i),
    .fire_o (fire)
  );

  sonar_range_calc #(
    .DIST_W      (DIST_W),
    .ECHO_W      (ECHO_W),
    .MIN_MM      (MIN_MM),
    .MAX_MM      (MAX_MM),
    .SCALE       (SCALE),
    .SCALE_W     (SCALE_W),
    .FRAC        (FRAC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_range_calc (
    .dist_i (dist_held),
    .len_o  (echo_len)
  );

  sonar_meas_fsm #(
    .HALF_CYC  (HALF_CYC),
    .PULSES    (BURST_PULSES),
    .CYCLE_CYC (CYCLE_CYC),
    .DIST_W    (DIST_W),
    .ECHO_W    (ECHO_W),
    .CYC_W     (CYC_W)
  ) u_meas_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .fire_i         (fire),
    .dist_i         (dist_mm_i),
    .echo_len_i     (echo_len),
    .dist_q_o       (dist_held),
    .burst_active_o (burst_active_o),
    .burst_wave_o   (burst_wave_o),
    .echo_o         (echo_o)
  );
endmodule

// File: tb/sonar_echo_emu_tb.sv
module sonar_echo_emu_tb;
  localparam int HALF    = 17;
  localparam int PULSES  = 8;
  localparam int GAP     = 1360;
  localparam int TIMEOUT = 680;

  logic        clk;
  logic        rst_n;
  logic        trig;
  logic [15:0] dist_mm;
  logic        echo, burst_active, burst_wave;
  int          vectors;
  int          miscompares;

  sonar_echo_emu #(
    .CLK_HZ     (1_360_000),
    .CYCLE_US   (1000),
    .TIMEOUT_US (500)
  ) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .trig_i         (trig),
    .dist_mm_i      (dist_mm),
    .echo_o         (echo),
    .burst_active_o (burst_active),
    .burst_wave_o   (burst_wave)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_len(int d);
    if (d > 4000) return TIMEOUT;
    if (d < 20) return 20 * 8;
    return d * 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // starts at a negedge, leaves trig low at the negedge tlen later
  task automatic pulse_trig(int tlen);
    trig = 1'b1;
    repeat (tlen) @(negedge clk);
    trig = 1'b0;
  endtask

  // called right after trig falls; returns negedges since first burst sample
  task automatic observe(bit exp_acc, int elen, string req, int new_dist,
                         bit poke, output int elapsed);
    int b, w, rises, e, bad;
    bit prev;
    elapsed = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(burst_active == 1'b0, "R9", int'(burst_active), 0);
    @(negedge clk);
    chk(burst_active == exp_acc, req, int'(burst_active), int'(exp_acc));
    if (!exp_acc) begin
      bad = 0;
      repeat (30) begin
        if (burst_active || echo) bad++;
        @(negedge clk);
      end
      chk(bad == 0, req, bad, 0);
      return;
    end
    b = 0; w = 0; rises = 0; prev = 1'b0;
    while (burst_active) begin
      b++;
      if (burst_wave) w++;
      if (burst_wave && !prev) rises++;
      prev = burst_wave;
      if (b == 5 && new_dist >= 0) dist_mm = 16'(new_dist);
      @(negedge clk);
    end
    chk(b == 2 * PULSES * HALF, "R2", b, 2 * PULSES * HALF);
    chk(rises == PULSES, "R2", rises, PULSES);
    chk(w == PULSES * HALF, "R2", w, PULSES * HALF);
    chk(echo == 1'b1, "R3", int'(echo), 1);
    e = 0; bad = 0;
    while (echo) begin
      e++;
      if (burst_active) bad++;
      if (poke && e == 100) trig = 1'b1;
      if (poke && e == 120) trig = 1'b0;
      @(negedge clk);
    end
    chk(e == elen, req, e, elen);
    if (poke) chk(bad == 0, "R7", bad, 0);
    elapsed = b + e;
  endtask

  task automatic settle(int elapsed);
    if (elapsed < GAP + 40) repeat (GAP + 40 - elapsed) @(negedge clk);
  endtask

  task automatic run_meas(int d, int tlen, bit exp_acc, int elen, string req,
                          int new_dist, bit poke, output int elapsed);
    dist_mm = 16'(d);
    @(negedge clk);
    pulse_trig(tlen);
    observe(exp_acc, elen, req, new_dist, poke, elapsed);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int el;
    vectors = 0;
    miscompares = 0;
    trig = 1'b0;
    dist_mm = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(echo == 1'b0, "R11", int'(echo), 0);
    chk(burst_active == 1'b0, "R11", int'(burst_active), 0);
    chk(burst_wave == 1'b0, "R11", int'(burst_wave), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: width threshold
    run_meas(100, 1, 1'b0, 0, "R1", -1, 1'b0, el);
    run_meas(100, 13, 1'b0, 0, "R1", -1, 1'b0, el);
    run_meas(100, 14, 1'b1, 800, "R1", -1, 1'b0, el);
    settle(el);

    // R4 / R5: sweep across the clamp region
    for (int d = 0; d <= 40; d++) begin
      run_meas(d, 20, 1'b1, exp_len(d), (d < 20) ? "R5" : "R4", -1, 1'b0, el);
      settle(el);
    end

    // R4 far limit, R6 no-target timeout
    run_meas(4000, 20, 1'b1, exp_len(4000), "R4", -1, 1'b0, el);
    settle(el);
    run_meas(4001, 20, 1'b1, TIMEOUT, "R6", -1, 1'b0, el);
    settle(el);
    run_meas(65535, 20, 1'b1, TIMEOUT, "R6", -1, 1'b0, el);
    settle(el);

    // R10: distance change during burst has no effect
    run_meas(50, 20, 1'b1, exp_len(50), "R10", 300, 1'b0, el);
    settle(el);

    // R7: valid trigger during echo ignored
    run_meas(2000, 20, 1'b1, exp_len(2000), "R4", -1, 1'b1, el);
    settle(el);

    // R8: cycle boundary, release at count 1356 rejected, 1357 taken
    run_meas(20, 20, 1'b1, exp_len(20), "R4", -1, 1'b0, el);
    repeat (1356 - 20 - el) @(negedge clk);
    dist_mm = 16'd25;
    pulse_trig(20);
    observe(1'b0, 0, "R8", -1, 1'b0, el);
    settle(0);
    run_meas(20, 20, 1'b1, exp_len(20), "R4", -1, 1'b0, el);
    repeat (1357 - 20 - el) @(negedge clk);
    dist_mm = 16'd25;
    pulse_trig(20);
    observe(1'b1, exp_len(25), "R8", -1, 1'b0, el);
    settle(el);

    // R11: reset during echo, then immediate acceptance
    dist_mm = 16'd100;
    @(negedge clk);
    pulse_trig(20);
    repeat (3 + 2 * PULSES * HALF + 50) @(negedge clk);
    chk(echo == 1'b1, "R3", int'(echo), 1);
    rst_n = 1'b0;
    #1;
    chk(echo == 1'b0, "R11", int'(echo), 0);
    chk(burst_active == 1'b0, "R11", int'(burst_active), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_meas(30, 20, 1'b1, exp_len(30), "R11", -1, 1'b0, el);

    summary();
  end
endmodule